// File: doc/BRIEF.md
# Half-Group Memory Access Coalescer

This block sits between a 16-lane execution group and the memory request path. For one memory instruction, every lane presents a byte address, an access size and an active bit. The block folds these lane accesses into as few aligned memory transactions as the selected rule set allows. It then hands the transactions out one at a time on a valid/ready port. Each transaction carries a base address, a size code and a mask of the lanes it serves, so the memory side can return data to the right lanes.

Two rule sets are available, and the mode is latched with each request. The strict set coalesces only a fully ordered pattern. In that pattern, lane k touches element k of one region whose start is aligned to the region's size. Any other pattern falls back to one transaction per active lane. The relaxed set merges every unserved active lane whose address lies in the same aligned segment as the lowest unserved lane. It then shrinks that transaction by repeated halving while only one half of it is in use. The block takes a new request only after the last transaction of the previous one has been handshaken.

Top module: `hwc_coalescer`

## Requirements
- R1: While and just after reset, txn_valid is 0 and req_ready is 1.
- R2: Strict mode (req_mode=0). If every active lane has size code c in 2..4 (access bytes = 1<<c), and the lowest active lane's address minus lane*(1<<c) gives a base that is a multiple of 16<<c, and every active lane k has address base + k*(1<<c), then exactly one transaction is issued. It has txn_addr=base, txn_size=c+4 (txn_size is log2 of bytes) and txn_mask = the active mask.
- R3: In strict mode, inactive lanes are ignored: their address and size never stop coalescing.
- R4: When the strict rules fail (permuted, misaligned, mixed sizes, or size code 0 or 1), strict mode issues one transaction per active lane in ascending lane order. Each has txn_addr = the lane address, txn_size = the lane's size code, and a one-hot txn_mask (bit k = lane k).
- R5: In relaxed mode (req_mode=1), the first segment is 32, 64 or 128 bytes for lead size codes 0, 1 and 2..4 respectively, aligned down from the lead lane's address. One transaction serves every unserved active lane whose address falls in that segment, whatever the order.
- R6: In relaxed mode, while the segment is larger than 32 bytes and all served addresses lie in one half, the transaction shrinks to that half. Relaxed transactions are therefore aligned to their own size, with txn_size in 5..7.
- R7: Transactions come out in the order of the lowest still unserved active lane. Every lane is served exactly once, and nothing extra is issued.
- R8: While txn_valid=1 and txn_ready=0, the transaction stays valid and its fields do not change.
- R9: req_ready is 0 from the accepted request until the handshake of its last transaction. It is 1 in the cycle after that handshake.
- R10: A request with no active lane issues no transaction, and req_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_mode | input | 1 | 0 strict rules, 1 relaxed rules |
| req_addr | input | N*AW | Lane byte addresses, lane k at bits [k*AW +: AW] |
| req_size | input | N*3 | Lane size codes, bytes = 1<<code, lane k at bits [k*3 +: 3] |
| req_active | input | N | Lane active bits |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Memory side takes the transaction |
| txn_addr | output | AW | Transaction base byte address |
| txn_size | output | 4 | log2 of transaction bytes |
| txn_mask | output | N | Lanes served by this transaction |

## Verification
Two functions can land in the same cycle: the handshake of a transaction and the loading of the next one from the pending lanes. Another such pair is the handshake of the last transaction and the return of req_ready. The bench provokes both with a randomly throttled txn_ready, so a stall and an immediate take happen on neighbouring edges. It compares every handshaken transaction against a list built by its own model of the rules. It also checks that a stalled transaction holds its fields and that req_ready comes back exactly one cycle after the final take.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  localparam int unsigned SZ_W = 3;
  localparam int unsigned TS_W = 4;
  localparam logic MODE_STRICT  = 1'b0;
  localparam logic MODE_RELAXED = 1'b1;

  // first relaxed segment code: grows with access size, capped at max
  function automatic logic [TS_W-1:0] seg_start(input logic [SZ_W-1:0] sz,
                                                input int unsigned min_c,
                                                input int unsigned max_c);
    int unsigned c;
    c = min_c + 32'(sz);
    if (c > max_c) c = max_c;
    return TS_W'(c);
  endfunction
endpackage

// File: rtl/hwc_lead_pick.sv
module hwc_lead_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/hwc_strict_check.sv
module hwc_strict_check import hwc_pkg::*; #(
  parameter int N          = 16,
  parameter int AW         = 32,
  parameter int STRICT_MIN = 2,
  parameter int STRICT_MAX = 4
) (
  input  logic [N*AW-1:0]   addr_flat,
  input  logic [N*SZ_W-1:0] size_flat,
  input  logic [N-1:0]      active,
  output logic              ok,
  output logic [AW-1:0]     base,
  output logic [TS_W-1:0]   code
);
  localparam int IW  = $clog2(N);
  localparam int LGN = $clog2(N);

  logic            found;
  logic [IW-1:0]   lead;
  logic [AW-1:0]   lead_addr;
  logic [SZ_W-1:0] lead_sz;
  logic [TS_W-1:0] rcode;
  logic [AW-1:0]   low_mask;
  logic            size_legal;
  logic [N-1:0]    good;

  hwc_lead_pick #(.N(N)) u_lead (.vec(active), .found(found), .idx(lead));

  assign lead_addr  = addr_flat[32'(lead)*AW +: AW];
  assign lead_sz    = size_flat[32'(lead)*SZ_W +: SZ_W];
  assign rcode      = TS_W'(lead_sz) + TS_W'(LGN);
  assign low_mask   = (AW'(1) << rcode) - AW'(1);
  assign base       = lead_addr & ~low_mask;
  assign size_legal = (32'(lead_sz) >= STRICT_MIN) && (32'(lead_sz) <= STRICT_MAX);

  // every live lane must sit at its own slot of the aligned region
  for (genvar k = 0; k < N; k++) begin : g_lane
    assign good[k] = !active[k] ||
                     ((size_flat[k*SZ_W +: SZ_W] == lead_sz) &&
                      (addr_flat[k*AW +: AW] == base + (AW'(k) << lead_sz)));
  end

  assign ok   = found && size_legal && (&good);
  assign code = rcode;
endmodule

// File: rtl/hwc_segment_merge.sv
module hwc_segment_merge import hwc_pkg::*; #(
  parameter int N       = 16,
  parameter int AW      = 32,
  parameter int MIN_SEG = 5,
  parameter int MAX_SEG = 7
) (
  input  logic [N*AW-1:0]   addr_flat,
  input  logic [N*SZ_W-1:0] size_flat,
  input  logic [N-1:0]      pend,
  output logic [AW-1:0]     base,
  output logic [TS_W-1:0]   code,
  output logic [N-1:0]      mask
);
  localparam int IW     = $clog2(N);
  localparam int STEPS  = MAX_SEG - MIN_SEG;

  logic            found;
  logic [IW-1:0]   lead;
  logic [AW-1:0]   lead_addr;
  logic [SZ_W-1:0] lead_sz;
  logic [TS_W-1:0] start_c;
  logic [AW-1:0]   hi_mask;
  logic [N-1:0]    member;

  hwc_lead_pick #(.N(N)) u_lead (.vec(pend), .found(found), .idx(lead));

  assign lead_addr = addr_flat[32'(lead)*AW +: AW];
  assign lead_sz   = size_flat[32'(lead)*SZ_W +: SZ_W];
  assign start_c   = seg_start(lead_sz, MIN_SEG, MAX_SEG);
  assign hi_mask   = ~((AW'(1) << start_c) - AW'(1));

  for (genvar k = 0; k < N; k++) begin : g_member
    assign member[k] = pend[k] &&
                       (((addr_flat[k*AW +: AW] ^ lead_addr) & hi_mask) == '0);
  end

  // halve while only one half of the window holds served addresses
  always_comb begin
    logic lo_use;
    logic hi_use;
    logic [TS_W-1:0] cur_c;
    logic [AW-1:0]   cur_b;
    cur_c  = start_c;
    cur_b  = lead_addr & hi_mask;
    lo_use = 1'b0;
    hi_use = 1'b0;
    for (int s = 0; s < STEPS; s++) begin
      if (cur_c > TS_W'(MIN_SEG)) begin
        lo_use = 1'b0;
        hi_use = 1'b0;
        for (int k = 0; k < N; k++) begin
          if (member[k]) begin
            if (addr_flat[k*AW + 32'(cur_c) - 1]) hi_use = 1'b1;
            else                                  lo_use = 1'b1;
          end
        end
        if (!(lo_use && hi_use)) begin
          cur_c = cur_c - TS_W'(1);
          if (hi_use) cur_b = cur_b | (AW'(1) << cur_c);
        end
      end
    end
    base = cur_b;
    code = cur_c;
  end

  assign mask = found ? member : '0;
endmodule

// File: rtl/hwc_coalescer.sv
module hwc_coalescer import hwc_pkg::*; #(
  parameter int N       = 16,
  parameter int AW      = 32,
  parameter int MIN_SEG = 5,
  parameter int MAX_SEG = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_mode,
  input  logic [N*AW-1:0]     req_addr,
  input  logic [N*SZ_W-1:0]   req_size,
  input  logic [N-1:0]        req_active,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic [AW-1:0]       txn_addr,
  output logic [TS_W-1:0]     txn_size,
  output logic [N-1:0]        txn_mask
);
  localparam int IW = $clog2(N);

  logic                busy_q;
  logic                mode_q;
  logic [N*AW-1:0]     addr_q;
  logic [N*SZ_W-1:0]   size_q;
  logic [N-1:0]        pend_q;
  logic                sok_q;
  logic [AW-1:0]       sbase_q;
  logic [TS_W-1:0]     scode_q;
  logic                tv_q;
  logic [AW-1:0]       ta_q;
  logic [TS_W-1:0]     ts_q;
  logic [N-1:0]        tm_q;

  logic                sok_d;
  logic [AW-1:0]       sbase_d;
  logic [TS_W-1:0]     scode_d;
  logic [AW-1:0]       rx_base;
  logic [TS_W-1:0]     rx_code;
  logic [N-1:0]        rx_mask;
  logic                fb_found;
  logic [IW-1:0]       fb_lead;
  logic [AW-1:0]       nx_addr;
  logic [TS_W-1:0]     nx_size;
  logic [N-1:0]        nx_mask;
  logic                advance;

  // strict pattern judged once, on the incoming request
  hwc_strict_check #(.N(N), .AW(AW)) u_strict (
    .addr_flat(req_addr), .size_flat(req_size), .active(req_active),
    .ok(sok_d), .base(sbase_d), .code(scode_d)
  );

  hwc_segment_merge #(.N(N), .AW(AW), .MIN_SEG(MIN_SEG), .MAX_SEG(MAX_SEG)) u_seg (
    .addr_flat(addr_q), .size_flat(size_q), .pend(pend_q),
    .base(rx_base), .code(rx_code), .mask(rx_mask)
  );

  hwc_lead_pick #(.N(N)) u_fb (.vec(pend_q), .found(fb_found), .idx(fb_lead));

  always_comb begin
    if (mode_q == MODE_RELAXED) begin
      nx_addr = rx_base;
      nx_size = rx_code;
      nx_mask = rx_mask;
    end else if (sok_q) begin
      nx_addr = sbase_q;
      nx_size = scode_q;
      nx_mask = pend_q;
    end else begin
      nx_addr = addr_q[32'(fb_lead)*AW +: AW];
      nx_size = TS_W'(size_q[32'(fb_lead)*SZ_W +: SZ_W]);
      nx_mask = N'(1) << fb_lead;
    end
  end

  assign advance = busy_q && (!tv_q || txn_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      mode_q  <= MODE_STRICT;
      addr_q  <= '0;
      size_q  <= '0;
      pend_q  <= '0;
      sok_q   <= 1'b0;
      sbase_q <= '0;
      scode_q <= '0;
      tv_q    <= 1'b0;
      ta_q    <= '0;
      ts_q    <= '0;
      tm_q    <= '0;
    end else if (!busy_q) begin
      if (req_valid) begin
        busy_q  <= |req_active;
        mode_q  <= req_mode;
        addr_q  <= req_addr;
        size_q  <= req_size;
        pend_q  <= req_active;
        sok_q   <= sok_d;
        sbase_q <= sbase_d;
        scode_q <= scode_d;
      end
    end else if (advance) begin
      if (fb_found) begin
        tv_q   <= 1'b1;
        ta_q   <= nx_addr;
        ts_q   <= nx_size;
        tm_q   <= nx_mask;
        pend_q <= pend_q & ~nx_mask;
      end else begin
        tv_q   <= 1'b0;
        busy_q <= 1'b0;
      end
    end
  end

  assign req_ready = !busy_q;
  assign txn_valid = tv_q;
  assign txn_addr  = ta_q;
  assign txn_size  = ts_q;
  assign txn_mask  = tm_q;

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr) && $stable(txn_size) && $stable(txn_mask)); // R8
  AST_NO_ACCEPT_WHILE_ISSUING: assert property (@(posedge clk) disable iff (rst)
    txn_valid |-> !req_ready); // R9
  AST_MASK_FROM_PENDING: assert property (@(posedge clk) disable iff (rst)
    advance && fb_found |=> (txn_mask != '0) && ((txn_mask & ~$past(pend_q)) == '0)); // R7
  AST_RELAXED_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    txn_valid && (mode_q == MODE_RELAXED) |->
      (32'(txn_size) >= MIN_SEG) && (32'(txn_size) <= MAX_SEG) &&
      ((txn_addr & ((AW'(1) << txn_size) - AW'(1))) == '0)); // R6
  AST_FALLBACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    txn_valid && (mode_q == MODE_STRICT) && !sok_q |-> $onehot(txn_mask)); // R4
  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && (req_active == '0) |=> req_ready && !txn_valid); // R10
endmodule

// File: tb/hwc_coalescer_tb.sv
module hwc_coalescer_tb;
  localparam int N = 16;
  localparam int AW = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_mode = 1'b0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*3-1:0]  req_size = '0;
  logic [N-1:0]    req_active = '0;
  logic            txn_valid;
  logic            txn_ready = 1'b0;
  logic [AW-1:0]   txn_addr;
  logic [3:0]      txn_size;
  logic [N-1:0]    txn_mask;

  always #4 clk = ~clk;

  hwc_coalescer #(.N(N), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_addr(req_addr), .req_size(req_size),
    .req_active(req_active), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_addr(txn_addr), .txn_size(txn_size), .txn_mask(txn_mask)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] c_addr [N];
  logic [2:0]  c_sz   [N];
  logic [N-1:0] c_act;
  logic        c_mode;

  logic [31:0] e_addr [N];
  logic [3:0]  e_size [N];
  logic [N-1:0] e_mask [N];
  int          e_n;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act_v, input longint exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  function automatic int lead_of(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return -1;
  endfunction

  // expected transaction list, built from the requirement text
  task automatic model();
    e_n = 0;
    if (c_act == '0) return;
    if (c_mode == 1'b0) begin
      int ld;
      int s;
      bit ok;
      logic [31:0] b;
      ld = lead_of(c_act);
      s  = int'(c_sz[ld]);
      ok = (s >= 2) && (s <= 4);
      b  = c_addr[ld] - 32'(ld << s);
      if ((b % 32'(16 << s)) != 0) ok = 0;
      for (int k = 0; k < N; k++)
        if (c_act[k] && ((int'(c_sz[k]) != s) || (c_addr[k] != b + 32'(k << s)))) ok = 0;
      if (ok) begin
        e_addr[0] = b; e_size[0] = 4'(s + 4); e_mask[0] = c_act; e_n = 1;
      end else begin
        for (int k = 0; k < N; k++) if (c_act[k]) begin
          e_addr[e_n] = c_addr[k]; e_size[e_n] = 4'(c_sz[k]);
          e_mask[e_n] = N'(1) << k; e_n++;
        end
      end
    end else begin
      logic [N-1:0] pend;
      pend = c_act;
      while (pend != '0) begin
        int ld;
        int code;
        int lo;
        int hi;
        logic [31:0] base;
        logic [N-1:0] mem;
        ld   = lead_of(pend);
        code = 5 + int'(c_sz[ld]);
        if (code > 7) code = 7;
        base = (c_addr[ld] >> code) << code;
        lo = 1000; hi = -1; mem = '0;
        for (int k = 0; k < N; k++) begin
          if (pend[k] && c_addr[k] >= base && c_addr[k] < base + 32'(1 << code)) begin
            int off;
            off = int'(c_addr[k] - base);
            mem[k] = 1'b1;
            if (off < lo) lo = off;
            if (off > hi) hi = off;
          end
        end
        while (code > 5) begin
          int half;
          half = 1 << (code - 1);
          if (hi < half) code--;
          else if (lo >= half) begin
            base = base + 32'(half); lo -= half; hi -= half; code--;
          end else break;
        end
        e_addr[e_n] = base; e_size[e_n] = 4'(code); e_mask[e_n] = mem; e_n++;
        pend = pend & ~mem;
      end
    end
  endtask

  task automatic send();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    for (int k = 0; k < N; k++) begin
      req_addr[k*AW +: AW] = c_addr[k];
      req_size[k*3 +: 3]   = c_sz[k];
    end
    req_active = c_act;
    req_mode   = c_mode;
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid  = 1'b0;
    model();
    if (e_n == 0) begin
      check(req_ready == 1'b1, "R10", "ready after empty request", req_ready, 1);
      check(txn_valid == 1'b0, "R10", "no transaction for empty request", txn_valid, 0);
    end else begin
      int got;
      int guard;
      bit stalled;
      logic [31:0] pa;
      logic [3:0] ps;
      logic [N-1:0] pm;
      string tag;
      got = 0; guard = 0; stalled = 0; pa = '0; ps = '0; pm = '0;
      tag = c_mode ? "R5/R6/R7" : "R2/R3/R4/R7";
      check(req_ready == 1'b0, "R9", "ready low while busy", req_ready, 0);
      while (got < e_n && guard < 2000) begin
        guard++;
        if (stalled) begin
          check(txn_valid && txn_addr == pa && txn_size == ps && txn_mask == pm,
                "R8", "stalled transaction held", {txn_addr, txn_mask}, {pa, pm});
          stalled = 0;
        end
        if (txn_valid) begin
          if (($urandom % 4) != 0) begin
            txn_ready = 1'b1;
            check(txn_addr == e_addr[got], tag, "transaction address", txn_addr, e_addr[got]);
            check(txn_size == e_size[got], tag, "transaction size", txn_size, e_size[got]);
            check(txn_mask == e_mask[got], tag, "transaction mask", txn_mask, e_mask[got]);
            got++;
          end else begin
            txn_ready = 1'b0;
            stalled = 1; pa = txn_addr; ps = txn_size; pm = txn_mask;
          end
        end else begin
          txn_ready = 1'($urandom % 2);
        end
        @(negedge clk);
      end
      txn_ready = 1'b0;
      check(got == e_n, "R7", "transaction count", got, e_n);
      check(req_ready == 1'b1 && txn_valid == 1'b0, "R9", "ready back after last take",
            {req_ready, txn_valid}, 2'b10);
    end
  endtask

  task automatic set_linear(input logic [31:0] base, input int sz,
                            input logic [N-1:0] act, input logic mode);
    for (int k = 0; k < N; k++) begin
      c_addr[k] = base + 32'(k << sz);
      c_sz[k]   = 3'(sz);
    end
    c_act  = act;
    c_mode = mode;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R7 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] t;
    void'($urandom(32'h00c0a1e5));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(txn_valid == 1'b0, "R1", "valid in reset", txn_valid, 0);
    check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    check(txn_valid == 1'b0 && req_ready == 1'b1, "R1", "state after reset",
          {txn_valid, req_ready}, 2'b01);

    // R2 ordered 4/8/16-byte regions
    set_linear(32'd128, 2, '1, 1'b0); send();
    set_linear(32'd256, 3, '1, 1'b0); send();
    set_linear(32'd512, 4, '1, 1'b0); send();
    // R3 sparse lanes, junk in inactive ones
    set_linear(32'd128, 2, 16'h7ff6, 1'b0); c_addr[0] = 32'd9; c_sz[3] = 3'd0; send();
    // R4 permuted, misaligned, byte-sized
    set_linear(32'd128, 2, '1, 1'b0);
    t = c_addr[1]; c_addr[1] = c_addr[2]; c_addr[2] = t; send();
    set_linear(32'd132, 2, '1, 1'b0); send();
    set_linear(32'd64, 0, 16'h00f1, 1'b0); send();
    // R5 relaxed permuted inside one segment
    set_linear(32'd128, 2, '1, 1'b1);
    t = c_addr[0]; c_addr[0] = c_addr[9]; c_addr[9] = t; send();
    // R6 misaligned start splits into a 32-byte and a 64-byte piece
    set_linear(32'd116, 2, '1, 1'b1); send();
    set_linear(32'd200, 0, 16'h00ff, 1'b1); send();
    set_linear(32'd1024, 4, '1, 1'b1); send();
    // R10 empty requests in both modes
    set_linear(32'd0, 2, '0, 1'b0); send();
    set_linear(32'd0, 2, '0, 1'b1); send();

    for (int r = 0; r < 80; r++) begin
      int p;
      int sz;
      p  = int'($urandom % 4);
      sz = (p == 3) ? int'($urandom % 5) : 2 + int'($urandom % 3);
      set_linear(32'(($urandom % 64) * (16 << sz)), sz,
                 ($urandom % 2) ? '1 : N'($urandom), 1'($urandom % 2));
      if (p == 1) for (int k = 0; k < N; k++) c_addr[k] = c_addr[k] + 32'(1 << sz);
      if (p == 2) begin
        int a;
        int b;
        a = int'($urandom % N); b = int'($urandom % N);
        t = c_addr[a]; c_addr[a] = c_addr[b]; c_addr[b] = t;
      end
      if (p == 3) for (int k = 0; k < N; k++) begin
        int s2;
        s2 = ($urandom % 3 == 0) ? int'($urandom % 5) : sz;
        c_sz[k]   = 3'(s2);
        c_addr[k] = 32'(($urandom % 8) * 128) + 32'(($urandom % 32'(128 >> s2)) << s2);
      end
      send();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule